// File: doc/BRIEF.md
# Banked External Address Generator

This block forms the external memory address for an 8-bit controller core whose address and data pins are separate. For every access the core announces, the block drives three outputs. The first is a low address byte. The second is a high address byte. The third is a 4-bit extension nibble. The core reports the access kind together with the program counter, the data pointer, the accumulator and the indirect register. From these the block picks the source of the 16-bit address, and it registers the result so that all outputs move together on one clock edge.

Two registers sit behind a small special-function-register port. The page register supplies the upper address byte for register-indirect data accesses. The bank/mode register chooses what the nibble means:
- In bank mode, the nibble carries address bits 19:16, taken from the bank field. This happens only on table reads and data accesses. On instruction fetches the nibble is zero, so code always runs from the lowest 64 KB.
- In select mode, the nibble is four active-low chip selects, decoded from address bits 15:14. Each select covers one 16 KB region.

Top module: `bank_addr_gen`

## Requirements
- R1: While reset is high and until the first access is registered, all address outputs are 0. After reset, the page register reads 0x00 and the bank/mode register reads 0x70.
- R2: For an instruction fetch (access code 0), the registered 16-bit address {addr_hi, addr_lo} equals the program counter.
- R3: For a data-pointer data access (access code 2), addr_hi is the data pointer's upper byte and addr_lo is its lower byte.
- R4: For a register-indirect data access (access code 3), addr_hi is the page register and addr_lo is the indirect register.
- R5: For a table read (access code 1), the 16-bit address is (data pointer + zero-extended accumulator) modulo 65536.
- R6: With mode bit 7 of the bank/mode register at 0, ext_nib equals bank bits 3:0 for access codes 1, 2 and 3, and equals 0 for access code 0.
- R7: With mode bit 7 at 1, ext_nib has exactly one bit low for every access code. Bit k is low when address bits 15:14 of the same access equal k.
- R8: The bank/mode register sits at SFR address 0xA2. Bit 7 is the mode bit and bits 3:0 are the bank field. Bits 6:4 always read 111b, whatever value is written to them.
- R9: The page register sits at SFR address 0xA1. All 8 bits can be written and read back.
- R10: Reads of any other SFR address return 0x00. Writes to any other address leave both registers unchanged.
- R11: The outputs are registered. Inputs applied in one cycle appear on the outputs only after the next rising clock edge, and the outputs hold their previous value until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_type | input | 2 | Access kind: 0 fetch, 1 table read, 2 data-pointer data, 3 register-indirect data |
| pc | input | 16 | Program counter |
| dptr | input | 16 | Data pointer |
| acc_a | input | 8 | Accumulator (table-read offset) |
| ind_reg | input | 8 | Indirect register value |
| sfr_addr | input | 8 | SFR address |
| sfr_we | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| addr_lo | output | 8 | Address bits 7:0 |
| addr_hi | output | 8 | Address bits 15:8 |
| ext_nib | output | 4 | Address bits 19:16 or active-low chip selects |

## Verification
The bench sweeps both modes, four bank values and two page values. Within each of these it drives every access code with addresses placed in each of the four 16 KB quadrants. This separates the source selection per access kind, and it shows whether the nibble follows the bank field or the decoded quadrant. Table reads use offsets whose sum crosses a quadrant boundary, and in the top quadrant wraps past 0xFFFF. This exposes a missing carry, a carry that leaks beyond 16 bits, and chip selects decoded from the unsummed pointer. Before each clock edge, the bench also confirms that the outputs still hold the previous result. SFR traffic that sets reserved bits or targets unmapped addresses checks that such writes leave the registers untouched.

// File: rtl/bxa_pkg.sv
package bxa_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LOG_AW = 16;
    localparam int unsigned NIB_W  = 4;

    localparam logic [BYTE_W-1:0] SFR_PAGE_ADR = 8'hA1;
    localparam logic [BYTE_W-1:0] SFR_BANK_ADR = 8'hA2;
    localparam logic [BYTE_W-1:0] PAGE_RST     = 8'h00;
    localparam logic [BYTE_W-1:0] BANK_RST     = 8'h70;
    localparam logic [2:0]        RSVD_READ    = 3'b111;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_TABLE = 2'd1,
        ACC_DPTR  = 2'd2,
        ACC_INDIR = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [LOG_AW-1:0] addr;
        logic              ext_ok;
    } addr_req_t;

    typedef struct packed {
        logic             cs_mode;
        logic [NIB_W-1:0] bank;
    } bank_cfg_t;

    function automatic logic [BYTE_W-1:0] bank_view(bank_cfg_t c);
        return {c.cs_mode, RSVD_READ, c.bank};
    endfunction

    function automatic logic uses_bank(acc_kind_e k);
        return k != ACC_FETCH;
    endfunction

    function automatic bank_cfg_t bank_unpack(logic [BYTE_W-1:0] w);
        bank_cfg_t c;
        c.cs_mode = w[BYTE_W-1];
        c.bank    = w[NIB_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/bxa_sfr_file.sv
module bxa_sfr_file
    import bxa_pkg::*;
#(
    parameter int unsigned DAT_W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DAT_W-1:0] sfr_addr,
    input  logic             sfr_we,
    input  logic [DAT_W-1:0] sfr_wdata,
    output logic [DAT_W-1:0] sfr_rdata,
    output logic [DAT_W-1:0] page_q,
    output bank_cfg_t        cfg_q
);

    logic hit_page;
    logic hit_bank;

    assign hit_page = (sfr_addr == SFR_PAGE_ADR);
    assign hit_bank = (sfr_addr == SFR_BANK_ADR);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= PAGE_RST;
            cfg_q  <= bank_unpack(BANK_RST);
        end else if (sfr_we) begin
            if (hit_page) page_q <= sfr_wdata;
            if (hit_bank) cfg_q  <= bank_unpack(sfr_wdata);
        end
    end

    always_comb begin
        sfr_rdata = '0;
        if (hit_page)      sfr_rdata = page_q;
        else if (hit_bank) sfr_rdata = bank_view(cfg_q);
    end

endmodule

// File: rtl/bxa_addr_mux.sv
module bxa_addr_mux
    import bxa_pkg::*;
#(
    parameter int unsigned AW = LOG_AW,
    parameter int unsigned BW = BYTE_W
) (
    input  acc_kind_e     kind,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] dptr,
    input  logic [BW-1:0] acc_a,
    input  logic [BW-1:0] ind_reg,
    input  logic [BW-1:0] page_q,
    output addr_req_t     req
);

    localparam int unsigned PAD_W = AW - BW;

    logic [AW-1:0] table_sum;

    assign table_sum = dptr + {{PAD_W{1'b0}}, acc_a};

    always_comb begin
        req.ext_ok = uses_bank(kind);
        unique case (kind)
            ACC_FETCH: req.addr = pc;
            ACC_TABLE: req.addr = table_sum;
            ACC_DPTR:  req.addr = dptr;
            ACC_INDIR: req.addr = {page_q, ind_reg};
            default:   req.addr = pc;
        endcase
    end

endmodule

// File: rtl/bxa_nibble.sv
module bxa_nibble
    import bxa_pkg::*;
#(
    parameter int unsigned AW = LOG_AW,
    parameter int unsigned NW = NIB_W
) (
    input  bank_cfg_t   cfg,
    input  addr_req_t   req,
    output logic [NW-1:0] nib
);

    localparam int unsigned SEL_W = $clog2(NW);

    logic [SEL_W-1:0] region;
    logic [NW-1:0]    cs_n;

    assign region = req.addr[AW-1 -: SEL_W];

    for (genvar g = 0; g < NW; g++) begin : g_cs
        localparam logic [SEL_W-1:0] CODE = SEL_W'(g);
        assign cs_n[g] = (region != CODE);
    end

    always_comb begin
        if (cfg.cs_mode)     nib = cs_n;
        else if (req.ext_ok) nib = cfg.bank;
        else                 nib = '0;
    end

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bxa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  acc_type,
    input  logic [15:0] pc,
    input  logic [15:0] dptr,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  ind_reg,
    input  logic [7:0]  sfr_addr,
    input  logic        sfr_we,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_rdata,
    output logic [7:0]  addr_lo,
    output logic [7:0]  addr_hi,
    output logic [3:0]  ext_nib
);

    logic [BYTE_W-1:0] page_q;
    bank_cfg_t         cfg_q;
    addr_req_t         req;
    logic [NIB_W-1:0]  nib_d;
    acc_kind_e         kind;
    logic              cs_mode_q;
    logic [NIB_W-1:0]  bank_q;

    assign kind      = acc_kind_e'(acc_type);
    assign cs_mode_q = cfg_q.cs_mode;
    assign bank_q    = cfg_q.bank;

    bxa_sfr_file #(.DAT_W(BYTE_W)) u_sfr (
        .clk      (clk),
        .rst      (rst),
        .sfr_addr (sfr_addr),
        .sfr_we   (sfr_we),
        .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata),
        .page_q   (page_q),
        .cfg_q    (cfg_q)
    );

    bxa_addr_mux #(.AW(LOG_AW), .BW(BYTE_W)) u_mux (
        .kind   (kind),
        .pc     (pc),
        .dptr   (dptr),
        .acc_a  (acc_a),
        .ind_reg(ind_reg),
        .page_q (page_q),
        .req    (req)
    );

    bxa_nibble #(.AW(LOG_AW), .NW(NIB_W)) u_nib (
        .cfg(cfg_q),
        .req(req),
        .nib(nib_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo <= '0;
            addr_hi <= '0;
            ext_nib <= '0;
        end else begin
            addr_lo <= req.addr[BYTE_W-1:0];
            addr_hi <= req.addr[LOG_AW-1:BYTE_W];
            ext_nib <= nib_d;
        end
    end

endmodule

// File: rtl/bxa_chk.sv
module bxa_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  acc_type,
    input logic [15:0] pc,
    input logic [15:0] dptr,
    input logic [7:0]  ind_reg,
    input logic [7:0]  sfr_addr,
    input logic [7:0]  sfr_rdata,
    input logic [7:0]  addr_lo,
    input logic [7:0]  addr_hi,
    input logic [3:0]  ext_nib,
    input logic [7:0]  page_q,
    input logic        cs_mode_q,
    input logic [3:0]  bank_q
);

    a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
        (acc_type == 2'd0) |=> ({addr_hi, addr_lo} == $past(pc)));

    a_r3_dptr_addr: assert property (@(posedge clk) disable iff (rst)
        (acc_type == 2'd2) |=> ({addr_hi, addr_lo} == $past(dptr)));

    a_r4_indir_addr: assert property (@(posedge clk) disable iff (rst)
        (acc_type == 2'd3) |=> (addr_hi == $past(page_q) && addr_lo == $past(ind_reg)));

    a_r6_fetch_nib_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_type == 2'd0 && !cs_mode_q) |=> (ext_nib == 4'h0));

    a_r6_data_nib_bank: assert property (@(posedge clk) disable iff (rst)
        (acc_type != 2'd0 && !cs_mode_q) |=> (ext_nib == $past(bank_q)));

    a_r7_one_select: assert property (@(posedge clk) disable iff (rst)
        cs_mode_q |=> ($countones(~ext_nib) == 1));

    a_r8_rsvd_ones: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == 8'hA2) |-> (sfr_rdata[6:4] == 3'b111));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr != 8'hA1 && sfr_addr != 8'hA2) |-> (sfr_rdata == 8'h00));

endmodule

bind bank_addr_gen bxa_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_type (acc_type),
    .pc       (pc),
    .dptr     (dptr),
    .ind_reg  (ind_reg),
    .sfr_addr (sfr_addr),
    .sfr_rdata(sfr_rdata),
    .addr_lo  (addr_lo),
    .addr_hi  (addr_hi),
    .ext_nib  (ext_nib),
    .page_q   (page_q),
    .cs_mode_q(cs_mode_q),
    .bank_q   (bank_q)
);

// File: tb/bank_addr_gen_bench.sv
`timescale 1ns/1ps
module bank_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  acc_type;
    logic [15:0] pc, dptr;
    logic [7:0]  acc_a, ind_reg;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic        sfr_we;
    logic [7:0]  addr_lo, addr_hi;
    logic [3:0]  ext_nib;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic        m_mode;
    logic [3:0]  m_bank;
    logic [7:0]  m_page;
    logic [23:0] prev_exp;
    bit          prev_ok;

    always #2.5 clk = ~clk;

    bank_addr_gen u_bank_addr_gen (
        .clk(clk), .rst(rst), .acc_type(acc_type), .pc(pc), .dptr(dptr),
        .acc_a(acc_a), .ind_reg(ind_reg), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .ext_nib(ext_nib)
    );

    task automatic chk(string req, logic [23:0] got, logic [23:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [23:0] model(int kind, logic [15:0] p, logic [15:0] d,
                                          logic [7:0] a, logic [7:0] r);
        logic [15:0] ad;
        logic [3:0]  n;
        case (kind)
            0:       ad = p;
            1:       ad = d + {8'h00, a};
            2:       ad = d;
            default: ad = {m_page, r};
        endcase
        if (m_mode) n = ~(4'b0001 << ad[15:14]);
        else        n = (kind == 0) ? 4'h0 : m_bank;
        return {n, ad[15:8], ad[7:0]};
    endfunction

    task automatic sfr_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
        if (a == 8'hA1) m_page = d;
        if (a == 8'hA2) begin m_mode = d[7]; m_bank = d[3:0]; end
        prev_ok = 0;
    endtask

    task automatic sfr_rd(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        sfr_addr = a;
        #1;
        chk(req, {16'h0, sfr_rdata}, {16'h0, exp});
        prev_ok = 0;
    endtask

    task automatic apply(int kind, logic [15:0] p, logic [15:0] d,
                         logic [7:0] a, logic [7:0] r);
        logic [23:0] e;
        string tag;
        @(negedge clk);
        acc_type = kind[1:0]; pc = p; dptr = d; acc_a = a; ind_reg = r;
        e = model(kind, p, d, a, r);
        case (kind)
            0: tag = "R2";
            1: tag = "R5";
            2: tag = "R3";
            default: tag = "R4";
        endcase
        tag = {tag, m_mode ? "/R7" : "/R6"};
        #1;
        if (prev_ok) chk("R11 hold", {ext_nib, addr_hi, addr_lo}, prev_exp);
        @(posedge clk);
        #1;
        chk(tag, {ext_nib, addr_hi, addr_lo}, e);
        prev_exp = e;
        prev_ok  = 1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired before the sweep ended");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; acc_type = 2'd0; pc = 16'h0; dptr = 16'h0; acc_a = 8'h0;
        ind_reg = 8'h0; sfr_addr = 8'h00; sfr_we = 1'b0; sfr_wdata = 8'h0;
        m_mode = 1'b0; m_bank = 4'h0; m_page = 8'h00; prev_ok = 0; prev_exp = '0;
        repeat (4) @(negedge clk);
        // R1: outputs cleared during reset
        chk("R1 outputs in reset", {ext_nib, addr_hi, addr_lo}, 24'h0);
        rst = 1'b0;
        #1;
        chk("R1 outputs after release", {ext_nib, addr_hi, addr_lo}, 24'h0);
        sfr_rd("R1 page reset", 8'hA1, 8'h00);
        sfr_rd("R1 bank reset", 8'hA2, 8'h70);

        // R8: reserved bits always read as ones, mode/bank kept
        sfr_wr(8'hA2, 8'h8F);
        sfr_rd("R8 readback", 8'hA2, 8'hFF);
        sfr_wr(8'hA2, 8'h05);
        sfr_rd("R8 reserved cleared write", 8'hA2, 8'h75);
        // R9: page full width
        sfr_wr(8'hA1, 8'hA5);
        sfr_rd("R9 page", 8'hA1, 8'hA5);
        sfr_wr(8'hA1, 8'h5A);
        sfr_rd("R9 page", 8'hA1, 8'h5A);
        // R10: unmapped reads zero, writes have no effect
        sfr_wr(8'hA0, 8'h3C);
        sfr_wr(8'hA6, 8'hFF);
        sfr_rd("R10 unmapped read A0", 8'hA0, 8'h00);
        sfr_rd("R10 unmapped read A6", 8'hA6, 8'h00);
        sfr_rd("R10 page untouched", 8'hA1, 8'h5A);
        sfr_rd("R10 bank untouched", 8'hA2, 8'h75);

        for (int md = 0; md < 2; md++) begin
            for (int bi = 0; bi < 4; bi++) begin
                logic [3:0] bk;
                bk = (bi == 0) ? 4'h0 : (bi == 1) ? 4'h5 : (bi == 2) ? 4'hA : 4'hF;
                sfr_wr(8'hA2, {md[0], 3'b000, bk});
                sfr_rd("R8 sweep readback", 8'hA2, {md[0], 3'b111, bk});
                for (int pi = 0; pi < 2; pi++) begin
                    sfr_wr(8'hA1, (pi == 0) ? 8'h1E : 8'hC3);
                    for (int k = 0; k < 4; k++) begin
                        for (int q = 0; q < 4; q++) begin
                            logic [15:0] p, d;
                            logic [7:0]  a, r;
                            p = {q[1:0], 14'h1234 ^ {10'h0, bk}};
                            d = {q[1:0], 14'h3F80};
                            a = 8'h9C ^ {4'h0, bk};
                            r = 8'hE7 ^ {6'h0, q[1:0]};
                            apply(k, p, d, a, r);
                        end
                    end
                end
            end
        end
        done = 1;
        finish_run();
    end

endmodule